// File: doc/BRIEF.md
# Nine-Bit Address-Filtering Serial Receiver

This block sits on a slave node of a shared serial line, directly behind a receiver that delivers nine-bit characters: eight data bits and a ninth bit. A ninth bit of 1 marks the character as an address. A ninth bit of 0 marks it as data. The block decides whether this node is currently addressed. It forwards only the data characters meant for this node and drops everything else. Bit timing, deserialization and the use made of the forwarded bytes are handled elsewhere.

After reset the node listens for addresses only and drops all data. When an address character equals the node's own address, the node becomes selected and forwards the data characters that follow. Any later address character drops the node back to address-only listening. The node is selected again only if that new address is its own.

Top module: `nine_bit_addr_filter`

## Requirements
- R1: While reset is high and in the first cycle after it, `selected` is 0, `out_valid` is 0 and `out_data` is 0.
- R2: A data character (`rx_ninth`=0) that arrives while `selected` is 0 produces no `out_valid` pulse and leaves `out_data` unchanged.
- R3: An address character (`rx_ninth`=1) whose `rx_data` equals `node_addr` sets `selected` to 1 on the next cycle.
- R4: An address character whose `rx_data` differs from `node_addr` sets `selected` to 0 on the next cycle. This holds whether or not the node was selected before.
- R5: A data character that arrives while `selected` is 1 raises `out_valid` for exactly one cycle, on the next cycle. In that cycle `out_data` equals the character's byte, and `out_data` keeps that value afterwards.
- R6: An address character never raises `out_valid` on the next cycle, whatever its value.
- R7: A selected node that receives its own address again stays selected and keeps forwarding data.
- R8: In a cycle with `rx_valid` low, `selected` and `out_data` keep their values and `out_valid` is 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_valid | input | 1 | A received character is present this cycle |
| rx_ninth | input | 1 | Ninth bit of the character: 1 = address, 0 = data |
| rx_data | input | DATA_W | Eight data bits of the character |
| node_addr | input | DATA_W | This node's own address |
| selected | output | 1 | Node is currently addressed (registered) |
| out_valid | output | 1 | One-cycle strobe for a forwarded data byte |
| out_data | output | DATA_W | Last forwarded data byte |

## Verification
The bench builds the block with the default eight-bit character width. It drives `node_addr` as a live port and changes it partway through the run. This shows that the comparison uses the current address and not a value latched earlier. Directed sequences cover matching and non-matching addresses, both while idle and while selected. Streams of data characters go to a selected node and to an unselected one, and gaps are left with no character present. A long stretch of mixed random characters, weighted towards the node's own address, then exercises back-to-back reselection and deselection.

// File: rtl/nbaf_pkg.sv
package nbaf_pkg;
  localparam int CHAR_DATA_W = 8;

  typedef enum logic {
    LISTEN_ADDR_ONLY = 1'b0,
    LISTEN_ALL       = 1'b1
  } listen_e;
endpackage

// File: rtl/nbaf_addr_cmp.sv
module nbaf_addr_cmp #(
  parameter int DATA_W = nbaf_pkg::CHAR_DATA_W
) (
  input  logic [DATA_W-1:0] char_byte,
  input  logic [DATA_W-1:0] own_addr,
  output logic              is_mine
);
  always_comb begin
    is_mine = (char_byte == own_addr);
  end
endmodule

// File: rtl/nbaf_listen_fsm.sv
module nbaf_listen_fsm (
  input  logic clk,
  input  logic rst,
  input  logic chr_valid,
  input  logic chr_is_addr,
  input  logic addr_hit,
  output logic sel_q
);
  import nbaf_pkg::*;

  listen_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (chr_valid && chr_is_addr) begin
      // any address character re-arms the filter, then the new address decides
      state_d = LISTEN_ADDR_ONLY;
      if (addr_hit) state_d = LISTEN_ALL;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= LISTEN_ADDR_ONLY;
    else     state_q <= state_d;
  end

  assign sel_q = (state_q == LISTEN_ALL);

  p_match_selects_r3: assert property (@(posedge clk) disable iff (rst)
    (chr_valid && chr_is_addr && addr_hit) |=> sel_q);

  p_miss_deselects_r4: assert property (@(posedge clk) disable iff (rst)
    (chr_valid && chr_is_addr && !addr_hit) |=> !sel_q);

  p_idle_holds_sel_r8: assert property (@(posedge clk) disable iff (rst)
    (!chr_valid) |=> $stable(sel_q));
endmodule

// File: rtl/nbaf_data_out.sv
module nbaf_data_out #(
  parameter int DATA_W = nbaf_pkg::CHAR_DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              chr_valid,
  input  logic              chr_is_addr,
  input  logic [DATA_W-1:0] chr_byte,
  input  logic              sel_now,
  output logic              dv_q,
  output logic [DATA_W-1:0] dd_q
);
  logic take;

  always_comb begin
    take = chr_valid && !chr_is_addr && sel_now;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dv_q <= 1'b0;
      dd_q <= '0;
    end else begin
      dv_q <= take;
      if (take) dd_q <= chr_byte;
    end
  end

  p_unselected_drop_r2: assert property (@(posedge clk) disable iff (rst)
    (chr_valid && !chr_is_addr && !sel_now) |=> (!dv_q && $stable(dd_q)));

  p_strobe_byte_r5: assert property (@(posedge clk) disable iff (rst)
    (chr_valid && !chr_is_addr && sel_now) |=> (dv_q && dd_q == $past(chr_byte)));

  p_addr_not_data_r6: assert property (@(posedge clk) disable iff (rst)
    (chr_valid && chr_is_addr) |=> !dv_q);

  p_idle_no_strobe_r8: assert property (@(posedge clk) disable iff (rst)
    (!chr_valid) |=> (!dv_q && $stable(dd_q)));
endmodule

// File: rtl/nine_bit_addr_filter.sv
module nine_bit_addr_filter #(
  parameter int DATA_W = nbaf_pkg::CHAR_DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic              rx_ninth,
  input  logic [DATA_W-1:0] rx_data,
  input  logic [DATA_W-1:0] node_addr,
  output logic              selected,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);
  logic hit;
  logic sel_int;

  nbaf_addr_cmp #(.DATA_W(DATA_W)) u_cmp (
    .char_byte (rx_data),
    .own_addr  (node_addr),
    .is_mine   (hit)
  );

  nbaf_listen_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .chr_valid   (rx_valid),
    .chr_is_addr (rx_ninth),
    .addr_hit    (hit),
    .sel_q       (sel_int)
  );

  nbaf_data_out #(.DATA_W(DATA_W)) u_out (
    .clk         (clk),
    .rst         (rst),
    .chr_valid   (rx_valid),
    .chr_is_addr (rx_ninth),
    .chr_byte    (rx_data),
    .sel_now     (sel_int),
    .dv_q        (out_valid),
    .dd_q        (out_data)
  );

  assign selected = sel_int;

  p_reselect_own_r7: assert property (@(posedge clk) disable iff (rst)
    (selected && rx_valid && rx_ninth && rx_data == node_addr) |=> selected);

  p_reset_state_r1: assert property (@(posedge clk)
    $past(rst) |-> (!selected && !out_valid && out_data == '0));
endmodule

// File: tb/nine_bit_addr_filter_bench.sv
module nine_bit_addr_filter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          rx_valid = 1'b0;
  logic          rx_ninth = 1'b0;
  logic [DW-1:0] rx_data = '0;
  logic [DW-1:0] node_addr = 8'h3C;
  logic          selected, out_valid;
  logic [DW-1:0] out_data;

  int    n_checks = 0;
  int    n_fail = 0;
  string cur_req = "R1";
  bit    done = 0;

  // behavioural reference
  bit          m_sel = 0;
  bit          m_dv = 0;
  int unsigned m_dd = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nine_bit_addr_filter #(.DATA_W(DW)) u_nine_bit_addr_filter (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_ninth(rx_ninth),
    .rx_data(rx_data), .node_addr(node_addr), .selected(selected),
    .out_valid(out_valid), .out_data(out_data)
  );

  always @(posedge clk) begin
    if (rst) begin
      m_sel = 0; m_dv = 0; m_dd = 0;
    end else begin
      m_dv = 0;
      if (rx_valid) begin
        if (rx_ninth) m_sel = (rx_data == node_addr);
        else if (m_sel) begin
          m_dv = 1; m_dd = rx_data;
        end
      end
    end
  end

  task automatic check(string req, string what, int unsigned act, int unsigned exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      check(cur_req, "selected", selected, m_sel);
      check(cur_req, "out_valid", out_valid, m_dv);
      check(cur_req, "out_data", out_data, m_dd);
    end
  end

  task automatic send(bit ninth, logic [DW-1:0] b);
    @(negedge clk);
    rx_valid = 1; rx_ninth = ninth; rx_data = b;
    @(negedge clk);
    rx_valid = 0; rx_ninth = 0; rx_data = '0;
  endtask

  task automatic send_b2b(bit ninth, logic [DW-1:0] b);
    @(negedge clk);
    rx_valid = 1; rx_ninth = ninth; rx_data = b;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rx_valid = 0; rx_ninth = $urandom_range(0, 1); rx_data = DW'($urandom);
    end
    rx_ninth = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    // R1: reset state, checked directly and then by the per-cycle compare
    repeat (3) @(negedge clk);
    check("R1", "reset selected", selected, 0);
    check("R1", "reset out_valid", out_valid, 0);
    check("R1", "reset out_data", out_data, 0);
    rst = 0;
    cur_req = "R2";
    send(0, 8'h55); send(0, 8'h3C);
    check("R2", "no strobe unselected", out_valid, 0);
    cur_req = "R4";
    send(1, 8'h11); send(0, 8'h77);
    check("R4", "mismatch keeps idle", selected, 0);
    cur_req = "R3";
    send(1, 8'h3C);
    check("R3", "match selects", selected, 1);
    cur_req = "R5";
    send_b2b(0, 8'hA1); send_b2b(0, 8'hB2); send_b2b(0, 8'h00);
    @(negedge clk); rx_valid = 0;
    check("R5", "last byte held", out_data, 8'h00);
    cur_req = "R8";
    idle(5);
    check("R8", "idle keeps byte", out_data, 8'h00);
    cur_req = "R7";
    send_b2b(1, 8'h3C); send_b2b(0, 8'hC4);
    @(negedge clk); rx_valid = 0;
    check("R7", "reselected forwards", out_data, 8'hC4);
    cur_req = "R6";
    send(1, 8'h3C);
    check("R6", "own address not data", out_valid, 0);
    cur_req = "R4";
    send_b2b(1, 8'h3D); send_b2b(0, 8'hEE);
    @(negedge clk); rx_valid = 0;
    check("R4", "deselected drops", out_data, 8'hC4);
    check("R4", "deselected flag", selected, 0);
    cur_req = "R3";
    node_addr = 8'hA5;
    send(1, 8'hA5); send(0, 8'h5A);
    check("R3", "new port address", out_data, 8'h5A);
    cur_req = "R2";
    send(1, 8'h3C); send(0, 8'h99);
    check("R2", "old address now foreign", out_data, 8'h5A);
    cur_req = "R5";
    for (int i = 0; i < 2000; i++) begin
      int unsigned r = $urandom_range(0, 9);
      if (r < 2) send_b2b(1, 8'hA5);
      else if (r < 4) send_b2b(1, DW'($urandom));
      else if (r < 8) send_b2b(0, DW'($urandom));
      else begin @(negedge clk); rx_valid = 0; end
    end
    @(negedge clk); rx_valid = 0;
    cur_req = "R1";
    rst = 1;
    @(negedge clk); @(negedge clk);
    rst = 0;
    idle(2);
    finish_run();
  end
endmodule